// File: doc/BRIEF.md
# Serial ADC Conversion Controller

This block is the master side of a four-wire serial link to a 12-bit multi-channel analog-to-digital converter. A one-cycle request on `start_i`, with a channel number, a single-ended/differential choice and a mode bit, runs one conversion. The controller pulls chip select low and sends a five-bit command on the data-out line. It lets the converter's null bit pass and shifts in the 12-bit result, most significant bit first. It then raises chip select and presents the word with a one-cycle `done_o` pulse.

In extended mode the serial clock keeps running after the last result bit. The converter then sends the result again, least significant bit first, starting from bit 1. The controller collects those eleven echoed bits and compares them with bits 1 to 11 of the main word. `mismatch_o` goes high beside `done_o` if any of them differs. Between frames chip select stays high for a configured number of system clocks, and `busy_o` covers that gap, so a new request can never cut it short.

The serial clock idles low and runs at the system clock divided by `2*HALF_DIV`. The controller sets up data-out on the falling edge and samples data-in at the rising edge.

Top module: `adc_conv_ctrl`

## Requirements
- R1: After reset: `cs_n_o`=1, `sclk_o`=0, `busy_o`=0, `done_o`=0, `result_o`=0, `mismatch_o`=0.
- R2: The command is five bits. The converter samples them at serial clock rising edges 1 to 5 of the frame, in this order: a start bit of value 1, `sgl_i` (1 = single-ended), then `ch_i[2]`, `ch_i[1]`, `ch_i[0]`.
- R3: `sclk_o` is low whenever `cs_n_o` is high. Each level of `sclk_o` lasts `HALF_DIV` system clocks. `mosi_o` changes only while `sclk_o` is low.
- R4: Data-in is ignored at rising edges 1 to 7, where edge 7 carries the null bit. Result bit 11 is taken at edge 8 and the following bits down to bit 0 at edge 19.
- R5: A standard frame (`ext_i`=0 at the request) has exactly 19 rising edges. After the falling edge that follows the last one, chip select goes high. `done_o` then pulses with `result_o` valid and `mismatch_o`=0.
- R6: An extended frame (`ext_i`=1) has exactly 30 rising edges. The bits at edges 20 to 30 are compared with result bits 1 to 11 in that order. `mismatch_o` is 1 with `done_o` if any bit differs, and 0 if all match.
- R7: Between two frames `cs_n_o` stays high for at least `CSH_CYCLES` system clocks, even when `start_i` is held high.
- R8: A request while `busy_o` is high is ignored. It starts no frame and does not change the command of the frame in progress.
- R9: `busy_o` rises in the cycle after an accepted request, together with the falling edge of `cs_n_o`, and stays high through the chip-select hold. `done_o` lasts exactly one cycle and only occurs while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, sampled when idle |
| ch_i | input | 3 | Channel number |
| sgl_i | input | 1 | 1 = single-ended, 0 = differential |
| ext_i | input | 1 | 1 = extended frame with echo check |
| busy_o | output | 1 | Frame or chip-select hold in progress |
| done_o | output | 1 | One-cycle pulse: result ready |
| result_o | output | 12 | Converted word |
| mismatch_o | output | 1 | Echo differed from the result |
| cs_n_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Command data to converter |
| miso_i | input | 1 | Data from converter |

## Verification
The assertions take for granted that `start_i`, `ch_i`, `sgl_i` and `ext_i` are synchronous to `clk` and hold known values from reset on. They also assume the converter only ever reacts to the frames the controller makes. The bench changes every input at the falling system clock edge. Its converter model follows the frame edge by edge from the observed chip select and serial clock, and drives ones into the ignored window to expose any misalignment.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_HOLD = 2'd2
  } ctrl_state_t;

  localparam int CMD_BITS = 5;  // start, sgl, ch[2:0]
endpackage

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sclk_q, sclk_d;
  logic          term;

  assign term   = run_i && (cnt_q == CW'(HALF_DIV - 1));
  assign rise_o = term && !sclk_q;
  assign fall_o = term && sclk_q;
  assign sclk_o = sclk_q;

  always_comb begin
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    if (!run_i) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else if (term) begin
      cnt_d  = '0;
      sclk_d = !sclk_q;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end
endmodule

// File: rtl/adc_rx_capture.sv
module adc_rx_capture #(
  parameter int RES_W  = 12,
  parameter int LEAD   = 7,
  parameter int EDGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_i,
  input  logic [EDGE_W-1:0] bitno_i,
  input  logic              miso_i,
  output logic [RES_W-1:0]  res_o,
  output logic              echo_ok_o
);
  localparam int DATA_LO = LEAD + 1;
  localparam int DATA_HI = LEAD + RES_W;
  localparam int ECHO_HI = LEAD + 2 * RES_W - 1;

  logic [RES_W-1:0] res_q, res_d;
  logic [RES_W-2:0] echo_q, echo_d;
  logic             in_data, in_echo;

  assign in_data = (bitno_i >= EDGE_W'(DATA_LO)) && (bitno_i <= EDGE_W'(DATA_HI));
  assign in_echo = (bitno_i >  EDGE_W'(DATA_HI)) && (bitno_i <= EDGE_W'(ECHO_HI));

  always_comb begin
    res_d  = res_q;
    echo_d = echo_q;
    if (sample_i && in_data) res_d  = {res_q[RES_W-2:0], miso_i};
    if (sample_i && in_echo) echo_d = {miso_i, echo_q[RES_W-2:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      echo_q <= '0;
    end else begin
      res_q  <= res_d;
      echo_q <= echo_d;
    end
  end

  assign res_o     = res_q;
  assign echo_ok_o = (echo_q == res_q[RES_W-1:1]);
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl #(
  parameter int HALF_DIV   = 2,
  parameter int CSH_CYCLES = 6,
  parameter int RES_W      = 12,
  parameter int CH_W       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CH_W-1:0]  ch_i,
  input  logic             sgl_i,
  input  logic             ext_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [RES_W-1:0] result_o,
  output logic             mismatch_o,
  output logic             cs_n_o,
  output logic             sclk_o,
  output logic             mosi_o,
  input  logic             miso_i
);
  import adc_ctrl_pkg::*;

  localparam int CMD_W    = CH_W + 2;
  localparam int LEAD     = CMD_W + 2;
  localparam int LAST_STD = LEAD + RES_W;
  localparam int LAST_EXT = LAST_STD + RES_W - 1;
  localparam int EDGE_W   = $clog2(LAST_EXT + 1);
  localparam int HW       = $clog2(CSH_CYCLES + 1);

  ctrl_state_t      state_q, state_d;
  logic [EDGE_W-1:0] edge_q, edge_d, bitno;
  logic [HW-1:0]    hcnt_q, hcnt_d;
  logic [CMD_W-1:0] cmd_q, cmd_d;
  logic             ext_q, ext_d;
  logic             cs_q, cs_d;
  logic             done_q, done_d;
  logic             mis_q, mis_d;
  logic [RES_W-1:0] resv_q, resv_d;
  logic             rise, fall, last_hit;
  logic [RES_W-1:0] rx_res;
  logic             rx_ok;

  adc_sclk_gen #(.HALF_DIV(HALF_DIV)) u_sclk (
    .clk(clk), .rst_n(rst_n), .run_i(state_q == ST_XFER),
    .sclk_o(sclk_o), .rise_o(rise), .fall_o(fall)
  );

  assign bitno = edge_q + EDGE_W'(1);

  adc_rx_capture #(.RES_W(RES_W), .LEAD(LEAD), .EDGE_W(EDGE_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .sample_i(rise), .bitno_i(bitno),
    .miso_i(miso_i), .res_o(rx_res), .echo_ok_o(rx_ok)
  );

  assign last_hit = ext_q ? (edge_q == EDGE_W'(LAST_EXT))
                          : (edge_q == EDGE_W'(LAST_STD));

  always_comb begin
    state_d = state_q;
    edge_d  = edge_q;
    hcnt_d  = hcnt_q;
    cmd_d   = cmd_q;
    ext_d   = ext_q;
    cs_d    = cs_q;
    done_d  = 1'b0;
    mis_d   = mis_q;
    resv_d  = resv_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_XFER;
          cs_d    = 1'b0;
          edge_d  = '0;
          cmd_d   = {1'b1, sgl_i, ch_i};
          ext_d   = ext_i;
        end
      end
      ST_XFER: begin
        if (rise) edge_d = bitno;
        if (fall) begin
          if (last_hit) begin
            state_d = ST_HOLD;
            cs_d    = 1'b1;
            hcnt_d  = '0;
            done_d  = 1'b1;
            resv_d  = rx_res;
            mis_d   = ext_q && !rx_ok;
          end else begin
            cmd_d = {cmd_q[CMD_W-2:0], 1'b0};
          end
        end
      end
      ST_HOLD: begin
        if (hcnt_q == HW'(CSH_CYCLES - 1)) state_d = ST_IDLE;
        else hcnt_d = hcnt_q + HW'(1);
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      edge_q  <= '0;
      hcnt_q  <= '0;
      cmd_q   <= '0;
      ext_q   <= 1'b0;
      cs_q    <= 1'b1;
      done_q  <= 1'b0;
      mis_q   <= 1'b0;
      resv_q  <= '0;
    end else begin
      state_q <= state_d;
      edge_q  <= edge_d;
      hcnt_q  <= hcnt_d;
      cmd_q   <= cmd_d;
      ext_q   <= ext_d;
      cs_q    <= cs_d;
      done_q  <= done_d;
      mis_q   <= mis_d;
      resv_q  <= resv_d;
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign result_o   = resv_q;
  assign mismatch_o = mis_q;
  assign cs_n_o     = cs_q;
  assign mosi_o     = cmd_q[CMD_W-1];
endmodule

// File: rtl/adc_conv_ctrl_chk.sv
module adc_conv_ctrl_chk #(
  parameter int RES_W = 12,
  parameter int CH_W  = 3
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n_o,
  input logic sclk_o,
  input logic mosi_o,
  input logic busy_o,
  input logic done_o
);
  localparam int LAST_STD = CH_W + 4 + RES_W;
  localparam int LAST_EXT = LAST_STD + RES_W - 1;

  logic       cs_seen, sclk_seen;
  logic [7:0] rises;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_seen   <= 1'b1;
      sclk_seen <= 1'b0;
      rises     <= '0;
    end else begin
      cs_seen   <= cs_n_o;
      sclk_seen <= sclk_o;
      if (cs_seen && !cs_n_o)       rises <= '0;
      else if (!sclk_seen && sclk_o) rises <= rises + 8'd1;
    end
  end

  a_r3_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sclk_o);
  a_r3_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));
  a_r5_edge_count: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_o) |-> (rises == 8'(LAST_STD) || rises == 8'(LAST_EXT)));
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r9_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o);
  a_r8_frame_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> $rose(busy_o));
  a_r7_busy_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_o) |-> busy_o);
endmodule

bind adc_conv_ctrl adc_conv_ctrl_chk #(.RES_W(RES_W), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
  .mosi_o(mosi_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/adc_conv_ctrl_bench.sv
module adc_conv_ctrl_bench;
  localparam int HALF = 2;
  localparam int CSH  = 6;

  logic        clk, rst_n, start_i, sgl_i, ext_i, miso_i;
  logic [2:0]  ch_i;
  logic        busy_o, done_o, mismatch_o, cs_n_o, sclk_o, mosi_o;
  logic [11:0] result_o;

  int tests = 0, fails = 0;

  adc_conv_ctrl #(.HALF_DIV(HALF), .CSH_CYCLES(CSH)) u_adc_conv_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ch_i(ch_i), .sgl_i(sgl_i),
    .ext_i(ext_i), .busy_o(busy_o), .done_o(done_o), .result_o(result_o),
    .mismatch_o(mismatch_o), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
    .mosi_o(mosi_o), .miso_i(miso_i)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // converter model
  logic [11:0] word;
  logic        corrupt;
  int          rises, frames;
  logic [4:0]  cmd_cap;
  logic        cs_d, sclk_d;

  always @(posedge clk) begin
    cs_d   <= cs_n_o;
    sclk_d <= sclk_o;
    if (cs_d && !cs_n_o) begin
      rises   <= 0;
      frames  <= frames + 1;
      cmd_cap <= '0;
    end else if (!cs_n_o && !sclk_d && sclk_o) begin
      rises <= rises + 1;
      if (rises < 5) cmd_cap <= {cmd_cap[3:0], mosi_o};
    end
  end

  function automatic logic model_bit(int r);
    if (r < 7)   return 1'b1;
    if (r == 7)  return 1'b0;
    if (r <= 19) return word[19 - r];
    if (r <= 30) return word[r - 19] ^ (corrupt && r == 25);
    return 1'b0;
  endfunction

  assign miso_i = model_bit(rises + 1);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    chk(cs_n_o == 1'b1, "R1 cs_n", cs_n_o, 1);
    chk(sclk_o == 1'b0, "R1 sclk", sclk_o, 0);
    chk(busy_o == 1'b0, "R1 busy", busy_o, 0);
    chk(done_o == 1'b0, "R1 done", done_o, 0);
    chk(result_o == 12'h0, "R1 result", result_o, 0);
    chk(mismatch_o == 1'b0, "R1 mismatch", mismatch_o, 0);
  endtask

  task automatic t_conv(input logic [2:0] ch, input logic sgl, input logic ext,
                        input logic [11:0] w, input logic bad);
    int exp_r;
    exp_r = ext ? 30 : 19;
    @(negedge clk);
    word = w; corrupt = bad;
    ch_i = ch; sgl_i = sgl; ext_i = ext; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o && !cs_n_o, "R9 busy with cs fall", {busy_o, cs_n_o}, 2'b10);
    while (!done_o) @(negedge clk);
    chk(cmd_cap == {1'b1, sgl, ch}, "R2 command bits", cmd_cap, {1'b1, sgl, ch});
    chk(result_o == w, "R4 result", result_o, w);
    chk(rises == exp_r, ext ? "R6 edge count" : "R5 edge count", rises, exp_r);
    chk(cs_n_o && !sclk_o, "R5 cs high sclk low", {cs_n_o, sclk_o}, 2'b10);
    chk(mismatch_o == (ext && bad), ext ? "R6 mismatch" : "R5 mismatch",
        mismatch_o, ext && bad);
    @(negedge clk);
    chk(!done_o && busy_o, "R9 done one cycle", {done_o, busy_o}, 2'b01);
    while (busy_o) @(negedge clk);
  endtask

  task automatic t_ignore();
    int f0;
    f0 = frames;
    @(negedge clk);
    word = 12'h3C5; corrupt = 1'b0;
    ch_i = 3'd2; sgl_i = 1'b1; ext_i = 1'b0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (9) @(negedge clk);
    ch_i = 3'd5; sgl_i = 1'b0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o) @(negedge clk);
    chk(cmd_cap == 5'b11010, "R8 command unchanged", cmd_cap, 5'b11010);
    while (busy_o) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(frames == f0 + 1, "R8 no extra frame", frames - f0, 1);
    chk(cs_n_o && !busy_o, "R8 idle after", {cs_n_o, busy_o}, 2'b10);
  endtask

  task automatic t_hold();
    int hi;
    @(negedge clk);
    word = 12'h0F0; corrupt = 1'b0;
    ch_i = 3'd1; sgl_i = 1'b1; ext_i = 1'b0; start_i = 1'b1;
    while (!done_o) @(negedge clk);
    hi = 0;
    while (cs_n_o) begin
      hi++;
      @(negedge clk);
    end
    chk(hi >= CSH, "R7 cs high time", hi, CSH);
    start_i = 1'b0;
    while (!done_o) @(negedge clk);
    chk(result_o == 12'h0F0, "R7 second frame result", result_o, 12'h0F0);
    while (busy_o) @(negedge clk);
  endtask

  task automatic t_sclk_period();
    int lo;
    @(negedge clk);
    word = 12'h001; corrupt = 1'b0;
    ch_i = 3'd0; sgl_i = 1'b0; ext_i = 1'b0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!sclk_o) @(negedge clk);
    while (sclk_o) @(negedge clk);
    lo = 0;
    while (!sclk_o) begin
      lo++;
      @(negedge clk);
    end
    chk(lo == HALF, "R3 sclk low phase", lo, HALF);
    while (busy_o) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; ch_i = '0; sgl_i = 1'b0; ext_i = 1'b0;
    word = '0; corrupt = 1'b0; rises = 0; frames = 0; cmd_cap = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_conv(3'd5, 1'b1, 1'b0, 12'hA5C, 1'b0);
    t_conv(3'd2, 1'b0, 1'b0, 12'h801, 1'b0);
    t_conv(3'd7, 1'b1, 1'b0, 12'hFFF, 1'b0);
    t_conv(3'd3, 1'b1, 1'b1, 12'h6B9, 1'b0);
    t_conv(3'd6, 1'b0, 1'b1, 12'h6B9, 1'b1);
    t_conv(3'd0, 1'b1, 1'b0, 12'h000, 1'b0);
    t_ignore();
    t_hold();
    t_sclk_period();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule